// File: doc/BRIEF.md
# SPI Flash-to-Memory DMA Engine

This block is the bulk-copy engine of a SPI flash controller. Software uses a small register port to give it a flash start address, a memory start address and a length code. It then sets an enable bit. The engine converts the length code into a byte count and copies that many bytes, rounded up to whole 32-bit words. For each word it fetches from a flash word-read port and then writes to system memory. When the copy is complete it raises a done flag and waits for software to clear the enable bit.

The length code is biased, so a code of zero still moves data. The bias and the unit of the code depend on a build-time variant. The word variant ignores the two low bits of the code and adds four. The byte variant counts single bytes and adds one. The engine keeps a single word in flight. The remaining-byte counter saturates at zero, so a transfer cannot run away.

Top module: `flash_dma_engine`

## Requirements
- R1: The byte count moved is (field + S) rounded up to a multiple of 4. The field is bits 24:0 of the length register at offset 0x8C, and higher written bits are dropped. S is 4 on the word variant (BYTE_UNIT=0) and 1 on the byte variant (BYTE_UNIT=1). On the word variant, bits 1:0 of the field are forced to zero.
- R2: A length code of 0 moves one word on both variants. On the word variant, a code of 0x1FFFFFC gives a count of 0x2000000 bytes (32 MiB).
- R3: The remaining count drops by 4 for each word written and never wraps below zero. A read of offset 0x8C returns the remaining count whenever the engine is not idle, and returns the stored masked code when it is idle.
- R4: The flash address (offset 0x84) and the memory address (offset 0x88) read with bits 1:0 at zero. Each advances by 4 per word written. After a transfer each holds its aligned start plus the byte count.
- R5: Writing offset 0x80 with bit 0 set while the engine is idle starts a transfer. The flash request is visible in the next cycle, carrying the aligned flash address.
- R6: A flash request stays valid, with a stable address, until it is accepted. A memory write is raised only after the flash response arrives, and it carries the response word and the current memory address. No new flash request is raised until the memory write is accepted.
- R7: After the last word is accepted, bit 11 of the status register at offset 0x08 reads 1. The flag holds, even against new start writes, until offset 0x80 is written with bit 0 clear. That write clears the flag and returns the engine to idle.
- R8: While the engine is not idle, writes to offsets 0x84, 0x88 and 0x8C are ignored. A control write in that state changes only the interrupt-enable bit, bit 3, and cannot clear the enable bit (bit 0) of a running transfer.
- R9: The irq output equals the done flag ANDed with control bit 3.
- R10: After reset every register reads zero, no request or write is valid, and irq is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset for reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| fl_req_valid | output | 1 | Flash word request valid |
| fl_req_ready | input | 1 | Flash side accepts the request |
| fl_req_addr | output | ADDR_W | Flash byte address of the requested word |
| fl_rsp_valid | input | 1 | Flash response word valid |
| fl_rsp_data | input | 32 | Flash response word |
| mem_wr_valid | output | 1 | Memory write valid |
| mem_wr_ready | input | 1 | Memory side accepts the write |
| mem_wr_addr | output | ADDR_W | Memory byte address of the write |
| mem_wr_data | output | 32 | Word to write |
| irq | output | 1 | Level interrupt: done and interrupt enable |

## Verification
The hardest situation to reach from the ports is a register write that lands while a transfer is in progress. The bench creates it by starting a transfer and withholding flash ready, which parks the engine on an unaccepted request. It then tries to overwrite the addresses, the length and the enable bit, and reads each back before releasing the flash port. The 32 MiB boundary cannot be run to completion within the cycle budget. It is therefore checked through the remaining-count readback taken right after start, followed by a reset. Both variants are built side by side, so each length vector can be replayed on each decoding.

// File: rtl/fdma_pkg.sv
`timescale 1ns/1ps
// Shared types and register layout for the flash-to-memory DMA engine.
// Assumes a byte-offset register port with 32-bit data.
package fdma_pkg;
    localparam int WORD_W = 32;
    localparam int REG_AW = 8;

    localparam logic [REG_AW-1:0] OFF_STATUS = 8'h08;
    localparam logic [REG_AW-1:0] OFF_CTRL   = 8'h80;
    localparam logic [REG_AW-1:0] OFF_FLASH  = 8'h84;
    localparam logic [REG_AW-1:0] OFF_MEM    = 8'h88;
    localparam logic [REG_AW-1:0] OFF_LEN    = 8'h8C;

    localparam int CTRL_EN_BIT   = 0;
    localparam int CTRL_IEN_BIT  = 3;
    localparam int STAT_DONE_BIT = 11;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_REQ,
        ST_RD_WAIT,
        ST_WR,
        ST_DONE
    } fdma_state_e;
endpackage

// File: rtl/fdma_len_decode.sv
`timescale 1ns/1ps
// Turns a stored (already masked) length code into the byte count to move:
// code plus the variant's start length, rounded up to whole words.
// Assumes LEN_W wide codes; the result needs one extra bit for the carry.
module fdma_len_decode #(
    parameter int LEN_W     = 25,
    parameter bit BYTE_UNIT = 1'b0,
    localparam int CNT_W    = LEN_W + 1
) (
    input  logic [LEN_W-1:0] len_code,
    output logic [CNT_W-1:0] byte_cnt
);
    localparam int START_LEN = BYTE_UNIT ? 1 : 4;

    logic [CNT_W-1:0] biased;

    // Add the start length plus 3 so that truncation rounds up.
    always_comb begin
        biased = CNT_W'(len_code) + CNT_W'(START_LEN + 3);
    end

    assign byte_cnt = {biased[CNT_W-1:2], 2'b00};
endmodule

// File: rtl/fdma_regs.sv
`timescale 1ns/1ps
// Software-visible register file: control, addresses, length, status.
// Decodes start and clear requests, locks the programming registers while
// the engine is not idle and steps both word addresses after each word.
// Assumes reads are combinational from reg_addr.
module fdma_regs
    import fdma_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int LEN_W     = 25,
    parameter bit BYTE_UNIT = 1'b0,
    localparam int CNT_W    = LEN_W + 1,
    localparam int WA_W     = ADDR_W - 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    input  logic              idle,
    input  logic              done,
    input  logic [CNT_W-1:0]  rem,
    input  logic              step,
    output logic              start_p,
    output logic              clear_p,
    output logic [ADDR_W-1:0] flash_addr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [LEN_W-1:0]  len_code,
    output logic              irq_en
);
    logic             en_q;
    logic             ien_q;
    logic [WA_W-1:0]  flash_q;
    logic [WA_W-1:0]  mem_q;
    logic [LEN_W-1:0] len_q;
    logic [LEN_W-1:0] len_wd;
    logic             wr_ctrl;
    logic             prog_ok;

    assign wr_ctrl = reg_wr && (reg_addr == OFF_CTRL);
    assign prog_ok = reg_wr && idle;
    assign start_p = wr_ctrl && reg_wdata[CTRL_EN_BIT] && idle;
    assign clear_p = wr_ctrl && !reg_wdata[CTRL_EN_BIT] && done;

    generate
        if (BYTE_UNIT) begin : g_byte_len
            assign len_wd = reg_wdata[LEN_W-1:0];
        end else begin : g_word_len
            logic unused_low_bit;
            assign len_wd = {reg_wdata[LEN_W-1:2], 2'b00};
            assign unused_low_bit = reg_wdata[1];
        end
    endgenerate

    // Register updates: control bits, locked programming registers, stepping.
    always_ff @(posedge clk) begin : reg_update
        if (!rst_n) begin
            en_q    <= 1'b0;
            ien_q   <= 1'b0;
            flash_q <= '0;
            mem_q   <= '0;
            len_q   <= '0;
        end else begin
            if (wr_ctrl) ien_q <= reg_wdata[CTRL_IEN_BIT];
            if (start_p)      en_q <= 1'b1;
            else if (clear_p) en_q <= 1'b0;
            if (prog_ok && reg_addr == OFF_FLASH) flash_q <= reg_wdata[ADDR_W-1:2];
            else if (step)                        flash_q <= flash_q + 1'b1;
            if (prog_ok && reg_addr == OFF_MEM)   mem_q <= reg_wdata[ADDR_W-1:2];
            else if (step)                        mem_q <= mem_q + 1'b1;
            if (prog_ok && reg_addr == OFF_LEN)   len_q <= len_wd;
        end
    end

    assign flash_addr = {flash_q, 2'b00};
    assign mem_addr   = {mem_q, 2'b00};
    assign len_code   = len_q;
    assign irq_en     = ien_q;

    // Read mux: remaining count replaces the length code once started.
    always_comb begin : read_mux
        reg_rdata = '0;
        case (reg_addr)
            OFF_CTRL: begin
                reg_rdata[CTRL_EN_BIT]  = en_q;
                reg_rdata[CTRL_IEN_BIT] = ien_q;
            end
            OFF_FLASH:  reg_rdata = WORD_W'(flash_addr);
            OFF_MEM:    reg_rdata = WORD_W'(mem_addr);
            OFF_LEN:    reg_rdata = idle ? WORD_W'(len_q) : WORD_W'(rem);
            OFF_STATUS: reg_rdata[STAT_DONE_BIT] = done;
            default:    reg_rdata = '0;
        endcase
    end

    AST_LEN_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle && reg_wr && reg_addr == OFF_LEN) |=> $stable(len_q)); // R8

    AST_FLASH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (flash_q == $past(flash_q) + 1'b1)); // R4

    AST_MEM_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (mem_q == $past(mem_q) + 1'b1)); // R4
endmodule

// File: rtl/fdma_ctrl.sv
`timescale 1ns/1ps
// Transfer sequencer: one word at a time, flash request, flash response,
// memory write. Holds the saturating remaining-byte counter and the
// captured data word. Assumes the flash answers each accepted request
// with exactly one response.
module fdma_ctrl
    import fdma_pkg::*;
#(
    parameter int LEN_W  = 25,
    localparam int CNT_W = LEN_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_p,
    input  logic              clear_p,
    input  logic [CNT_W-1:0]  byte_cnt,
    output logic              fl_req_valid,
    input  logic              fl_req_ready,
    input  logic              fl_rsp_valid,
    input  logic [WORD_W-1:0] fl_rsp_data,
    output logic              mem_wr_valid,
    input  logic              mem_wr_ready,
    output logic [WORD_W-1:0] mem_wr_data,
    output logic              step,
    output logic              idle,
    output logic              done,
    output logic [CNT_W-1:0]  rem
);
    fdma_state_e       state_q;
    logic [CNT_W-1:0]  rem_q;
    logic [CNT_W-1:0]  rem_next;
    logic [WORD_W-1:0] data_q;

    assign rem_next = (rem_q < CNT_W'(4)) ? '0 : rem_q - CNT_W'(4);

    // Sequencer state, remaining count and data capture.
    always_ff @(posedge clk) begin : seq
        if (!rst_n) begin
            state_q <= ST_IDLE;
            rem_q   <= '0;
            data_q  <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (start_p) begin
                    rem_q   <= byte_cnt;
                    state_q <= ST_RD_REQ;
                end
                ST_RD_REQ: if (fl_req_ready) state_q <= ST_RD_WAIT;
                ST_RD_WAIT: if (fl_rsp_valid) begin
                    data_q  <= fl_rsp_data;
                    state_q <= ST_WR;
                end
                ST_WR: if (mem_wr_ready) begin
                    rem_q   <= rem_next;
                    state_q <= (rem_q <= CNT_W'(4)) ? ST_DONE : ST_RD_REQ;
                end
                ST_DONE: if (clear_p) state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign fl_req_valid = (state_q == ST_RD_REQ);
    assign mem_wr_valid = (state_q == ST_WR);
    assign mem_wr_data  = data_q;
    assign step         = mem_wr_valid && mem_wr_ready;
    assign idle         = (state_q == ST_IDLE);
    assign done         = (state_q == ST_DONE);
    assign rem          = rem_q;

    AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (rem_q <= $past(rem_q))); // R3

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_req_valid && !fl_req_ready) |=> fl_req_valid); // R6

    AST_WR_AFTER_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_wr_valid) |-> $past(fl_rsp_valid)); // R6

    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !clear_p) |=> done); // R7
endmodule

// File: rtl/flash_dma_engine.sv
`timescale 1ns/1ps
// Top of the flash-to-memory DMA engine: register file, length decoder
// and word sequencer. BYTE_UNIT picks the length-code variant.
// Assumes a single clock with synchronous active-low reset.
module flash_dma_engine
    import fdma_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int LEN_W     = 25,
    parameter bit BYTE_UNIT = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [7:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              fl_req_valid,
    input  logic              fl_req_ready,
    output logic [ADDR_W-1:0] fl_req_addr,
    input  logic              fl_rsp_valid,
    input  logic [31:0]       fl_rsp_data,
    output logic              mem_wr_valid,
    input  logic              mem_wr_ready,
    output logic [ADDR_W-1:0] mem_wr_addr,
    output logic [31:0]       mem_wr_data,
    output logic              irq
);
    localparam int CNT_W = LEN_W + 1;

    logic             idle, done, step, start_p, clear_p, irq_en;
    logic [CNT_W-1:0] rem, byte_cnt;
    logic [LEN_W-1:0] len_code;

    fdma_regs #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .BYTE_UNIT(BYTE_UNIT)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .idle(idle), .done(done),
        .rem(rem), .step(step), .start_p(start_p), .clear_p(clear_p),
        .flash_addr(fl_req_addr), .mem_addr(mem_wr_addr), .len_code(len_code),
        .irq_en(irq_en)
    );

    fdma_len_decode #(.LEN_W(LEN_W), .BYTE_UNIT(BYTE_UNIT)) u_len (
        .len_code(len_code), .byte_cnt(byte_cnt)
    );

    fdma_ctrl #(.LEN_W(LEN_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start_p(start_p), .clear_p(clear_p),
        .byte_cnt(byte_cnt), .fl_req_valid(fl_req_valid),
        .fl_req_ready(fl_req_ready), .fl_rsp_valid(fl_rsp_valid),
        .fl_rsp_data(fl_rsp_data), .mem_wr_valid(mem_wr_valid),
        .mem_wr_ready(mem_wr_ready), .mem_wr_data(mem_wr_data), .step(step),
        .idle(idle), .done(done), .rem(rem)
    );

    assign irq = done && irq_en;

    AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == OFF_CTRL && !reg_wdata[CTRL_IEN_BIT]) |=> !irq); // R9
endmodule

// File: tb/tb_flash_dma_engine.sv
`timescale 1ns/1ps
module tb_flash_dma_engine;
    localparam logic [7:0] A_STAT = 8'h08, A_CTRL = 8'h80, A_FL = 8'h84,
                           A_MEM = 8'h88, A_LEN = 8'h8C;

    typedef struct packed {
        logic bu; logic st;
        logic [31:0] code, fa, ma, bytes, rdlen;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, 32'h0000_0000, 32'h0000_1000, 32'h0000_8000, 32'h4,   32'h0},
        '{1'b0, 1'b0, 32'h0000_0004, 32'h0000_2003, 32'h0000_9001, 32'h8,   32'h4},
        '{1'b0, 1'b0, 32'h0000_0007, 32'h0000_3000, 32'h0000_A000, 32'h8,   32'h4},
        '{1'b0, 1'b1, 32'h0000_000F, 32'h0000_4002, 32'h0000_B003, 32'h10,  32'hC},
        '{1'b1, 1'b0, 32'h0000_0000, 32'h0000_5000, 32'h0000_C000, 32'h4,   32'h0},
        '{1'b1, 1'b0, 32'h0000_0003, 32'h0000_6001, 32'h0000_D000, 32'h4,   32'h3},
        '{1'b1, 1'b0, 32'h0000_0004, 32'h0000_7000, 32'h0000_E002, 32'h8,   32'h4},
        '{1'b1, 1'b1, 32'h0000_0100, 32'h0001_0000, 32'h0002_0000, 32'h104, 32'h100},
        '{1'b0, 1'b0, 32'hFE00_0013, 32'h0003_0000, 32'h0004_0000, 32'h14,  32'h10},
        '{1'b1, 1'b1, 32'hF000_001E, 32'h0005_0000, 32'h0006_0000, 32'h20,  32'h1E},
        '{1'b0, 1'b1, 32'h0000_002C, 32'h0007_0000, 32'h0008_0000, 32'h30,  32'h2C},
        '{1'b1, 1'b0, 32'h0000_0041, 32'h0009_0000, 32'h000A_0000, 32'h44,  32'h41}
    };

    logic clk = 1'b0, rst_n = 1'b0, sel = 1'b0;
    logic reg_wr = 1'b0;
    logic [7:0] reg_addr = 8'h0;
    logic [31:0] reg_wdata = '0, fl_rsp_data = '0;
    logic fl_req_ready = 1'b0, fl_rsp_valid = 1'b0, mem_wr_ready = 1'b0;

    logic [31:0] a_rdata, b_rdata, a_fla, b_fla, a_mema, b_mema, a_memd, b_memd;
    logic a_frv, b_frv, a_mwv, b_mwv, a_irq, b_irq;
    logic [31:0] v_rdata, v_fla, v_mema, v_memd;
    logic v_frv, v_mwv, v_irq;

    int checks = 0, fails = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    flash_dma_engine #(.BYTE_UNIT(1'b0)) dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr && !sel), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(a_rdata), .fl_req_valid(a_frv),
        .fl_req_ready(fl_req_ready && !sel), .fl_req_addr(a_fla),
        .fl_rsp_valid(fl_rsp_valid && !sel), .fl_rsp_data(fl_rsp_data),
        .mem_wr_valid(a_mwv), .mem_wr_ready(mem_wr_ready && !sel),
        .mem_wr_addr(a_mema), .mem_wr_data(a_memd), .irq(a_irq)
    );

    flash_dma_engine #(.BYTE_UNIT(1'b1)) dut_byte (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr && sel), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(b_rdata), .fl_req_valid(b_frv),
        .fl_req_ready(fl_req_ready && sel), .fl_req_addr(b_fla),
        .fl_rsp_valid(fl_rsp_valid && sel), .fl_rsp_data(fl_rsp_data),
        .mem_wr_valid(b_mwv), .mem_wr_ready(mem_wr_ready && sel),
        .mem_wr_addr(b_mema), .mem_wr_data(b_memd), .irq(b_irq)
    );

    assign v_rdata = sel ? b_rdata : a_rdata;
    assign v_fla   = sel ? b_fla   : a_fla;
    assign v_mema  = sel ? b_mema  : a_mema;
    assign v_memd  = sel ? b_memd  : a_memd;
    assign v_frv   = sel ? b_frv   : a_frv;
    assign v_mwv   = sel ? b_mwv   : a_mwv;
    assign v_irq   = sel ? b_irq   : a_irq;

    function automatic logic [31:0] pat(input logic [31:0] a);
        return a ^ 32'h5A3C_0F96;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: %s got %h exp %h", req, what, got, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = v_rdata;
    endtask

    // Flash and memory responder; ends when the done status bit is seen.
    task automatic serve(input bit stall, input logic [31:0] fa, input logic [31:0] ma,
                         output int words, output int errs, output bit done_seen);
        int cyc = 0;
        bit pend = 1'b0, hold = 1'b0;
        logic [31:0] paddr = '0, hold_addr = '0;
        logic [31:0] exp_f = fa & ~32'h3;
        logic [31:0] exp_m = ma & ~32'h3;
        words = 0; errs = 0; done_seen = 1'b0;
        reg_addr = A_STAT;
        while (!done_seen && cyc < 5000) begin
            @(negedge clk); #1;
            cyc++;
            if (v_rdata[11]) done_seen = 1'b1;
            fl_rsp_valid = 1'b0;
            if (hold && (!v_frv || v_fla != hold_addr)) errs++;
            hold = 1'b0;
            if (pend) begin
                fl_rsp_valid = 1'b1; fl_rsp_data = pat(paddr); pend = 1'b0;
            end
            fl_req_ready = stall ? cyc[0] : 1'b1;
            if (v_frv) begin
                if (v_mwv) errs++;
                if (fl_req_ready) begin
                    if (v_fla != exp_f) errs++;
                    paddr = v_fla; exp_f += 4; pend = 1'b1;
                end else begin
                    hold = 1'b1; hold_addr = v_fla;
                end
            end
            mem_wr_ready = stall ? ~cyc[1] : 1'b1;
            if (v_mwv && mem_wr_ready) begin
                if (v_mema != exp_m) errs++;
                if (v_memd != pat((fa & ~32'h3) + 32'(words * 4))) errs++;
                exp_m += 4; words++;
            end
        end
        fl_req_ready = 1'b0; mem_wr_ready = 1'b0; fl_rsp_valid = 1'b0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: run did not end got %h exp %h", 32'd0, 32'd1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] r;
        int words, errs;
        bit dn;

        // R10: reset state
        do_reset();
        @(negedge clk);
        reg_read(A_CTRL, r);  chk(r == 0, "R10", "ctrl after reset", r, 0);
        reg_read(A_FL, r);    chk(r == 0, "R10", "flash addr after reset", r, 0);
        reg_read(A_MEM, r);   chk(r == 0, "R10", "mem addr after reset", r, 0);
        reg_read(A_LEN, r);   chk(r == 0, "R10", "len after reset", r, 0);
        reg_read(A_STAT, r);  chk(r == 0, "R10", "status after reset", r, 0);
        chk(!v_frv && !v_mwv && !v_irq, "R10", "valids/irq after reset",
            {29'd0, v_frv, v_mwv, v_irq}, 0);

        // R8 / R6 / R7: park the engine on an unaccepted request
        sel = 1'b0;
        reg_write(A_FL, 32'h0000_0100);
        reg_write(A_MEM, 32'h0000_0200);
        reg_write(A_LEN, 32'h0000_0008);
        reg_write(A_CTRL, 32'h1);
        chk(v_frv && v_fla == 32'h100, "R5", "request after start", v_fla, 32'h100);
        repeat (3) @(negedge clk);
        #1;
        chk(v_frv && v_fla == 32'h100, "R6", "request held without ready", v_fla, 32'h100);
        reg_write(A_FL, 32'hDEAD_0000);
        reg_write(A_MEM, 32'hBEEF_0000);
        reg_write(A_LEN, 32'h0000_0040);
        reg_read(A_FL, r);  chk(r == 32'h100, "R8", "flash write while busy", r, 32'h100);
        reg_read(A_MEM, r); chk(r == 32'h200, "R8", "mem write while busy", r, 32'h200);
        reg_read(A_LEN, r); chk(r == 32'hC, "R8", "len write while busy", r, 32'hC);
        reg_write(A_CTRL, 32'h8);
        reg_read(A_CTRL, r); chk(r == 32'h9, "R8", "ctrl write while busy", r, 32'h9);
        chk(v_frv, "R8", "still requesting after ctrl write", {31'd0, v_frv}, 1);
        serve(1'b0, 32'h100, 32'h200, words, errs, dn);
        chk(words == 3 && errs == 0, "R6", "parked transfer words/errors", words, 3);
        chk(dn && v_irq, "R9", "irq with enable at done", {31'd0, v_irq}, 1);
        reg_write(A_CTRL, 32'h9);
        repeat (2) @(negedge clk);
        reg_read(A_STAT, r); chk(r == 32'h800, "R7", "done held against start write", r, 32'h800);
        reg_write(A_CTRL, 32'h0);
        reg_read(A_STAT, r); chk(r == 0, "R7", "done cleared", r, 0);
        reg_read(A_CTRL, r); chk(r == 0, "R7", "ctrl after clear", r, 0);
        chk(!v_irq, "R9", "irq after clear", {31'd0, v_irq}, 0);

        // Vector table over both variants
        for (int i = 0; i < NV; i++) begin
            vec_t v;
            logic [31:0] cw;
            v = VECS[i];
            sel = v.bu;
            cw = (i % 2 == 1) ? 32'h9 : 32'h1;
            reg_write(A_FL, v.fa);
            reg_write(A_MEM, v.ma);
            reg_write(A_LEN, v.code);
            reg_write(A_CTRL, cw);
            reg_read(A_LEN, r);
            chk(r == v.bytes, "R1", $sformatf("vec %0d byte count", i), r, v.bytes);
            chk(v_frv && v_fla == (v.fa & ~32'h3), "R5",
                $sformatf("vec %0d first request", i), v_fla, v.fa & ~32'h3);
            serve(v.st, v.fa, v.ma, words, errs, dn);
            chk(words == int'(v.bytes / 4), "R1",
                $sformatf("vec %0d words moved", i), words, v.bytes / 4);
            chk(errs == 0, "R6", $sformatf("vec %0d handshake/data errors", i), errs, 0);
            chk(dn, "R7", $sformatf("vec %0d done flag", i), {31'd0, dn}, 1);
            chk(v_irq == cw[3], "R9", $sformatf("vec %0d irq", i), {31'd0, v_irq}, {31'd0, cw[3]});
            reg_read(A_FL, r);
            chk(r == (v.fa & ~32'h3) + v.bytes, "R4",
                $sformatf("vec %0d flash end addr", i), r, (v.fa & ~32'h3) + v.bytes);
            reg_read(A_MEM, r);
            chk(r == (v.ma & ~32'h3) + v.bytes, "R4",
                $sformatf("vec %0d mem end addr", i), r, (v.ma & ~32'h3) + v.bytes);
            reg_read(A_LEN, r);
            chk(r == 0, "R3", $sformatf("vec %0d remaining at done", i), r, 0);
            reg_write(A_CTRL, cw & 32'h8);
            reg_read(A_STAT, r);
            chk(r == 0, "R7", $sformatf("vec %0d status after clear", i), r, 0);
            reg_read(A_LEN, r);
            chk(r == v.rdlen, "R3", $sformatf("vec %0d idle len readback", i), r, v.rdlen);
            reg_write(A_CTRL, 32'h0);
        end

        // R2: 32 MiB on the word variant, then abandon by reset
        sel = 1'b0;
        reg_write(A_LEN, 32'h01FF_FFFC);
        reg_write(A_CTRL, 32'h1);
        reg_read(A_LEN, r);
        chk(r == 32'h0200_0000, "R2", "word variant max count", r, 32'h0200_0000);
        do_reset();
        sel = 1'b1;
        reg_write(A_LEN, 32'h01FF_FFFF);
        reg_write(A_CTRL, 32'h1);
        reg_read(A_LEN, r);
        chk(r == 32'h0200_0000, "R1", "byte variant max count", r, 32'h0200_0000);
        do_reset();
        @(negedge clk);
        reg_read(A_LEN, r);
        chk(r == 0 && !v_frv, "R10", "reset ends running transfer", r, 0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule